// File: doc/BRIEF.md
# Register Bank with Write-Back and Operand Select

This block holds the architectural registers of a single-cycle core: thirty-two words of thirty-two bits each, all of them writable, register zero included. Two read ports return register contents combinationally from the addresses given in the current instruction. One write port updates the register named by the destination address on the rising clock edge when the write enable is high.

Two selections sit beside the storage. The word written back is the memory read data when the opcode is a load, and the ALU result for any other opcode. The second operand sent to the ALU is the instruction immediate when the opcode belongs to the immediate format, and the contents of the second source register otherwise. A debug output carries the low four bits of the first fourteen registers as packed BCD digits for a display.

Top module: `regbank_opsel`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every register is cleared to zero; after reset all reads and all debug digits return zero.
- R2: At a rising edge with `wr_en` high and `rst` low, the register addressed by `rd_addr` takes the write-back word and every other register keeps its value.
- R3: At a rising edge with `wr_en` low, no register changes, whatever the opcode, address and data inputs are.
- R4: The write-back word is `mem_rdata` when `opcode` is 5'b10000 (load) and `alu_res` for every other opcode.
- R5: `op_a` equals the current contents of the register addressed by `rs1_addr`, combinationally.
- R6: `op_b` equals `imm` when `opcode` is in the immediate set {5'b00000 to 5'b00111, 5'b10000, 5'b10110, 5'b11111}, and the contents of the register addressed by `rs2_addr` for every other opcode.
- R7: Register 0 is an ordinary register: it can be written to a nonzero value and reads back that value.
- R8: A read of the register being written in the same cycle returns the value held before the edge; the new value appears after the edge.
- R9: `dbg_digits[4k+3:4k]` equals bits 3:0 of register k, for k from 0 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| rd_addr | input | 5 | Destination register address |
| rs1_addr | input | 5 | First source register address |
| rs2_addr | input | 5 | Second source register address |
| opcode | input | 5 | Instruction opcode, selects write-back and second operand sources |
| alu_res | input | 32 | ALU result for write-back |
| mem_rdata | input | 32 | Memory read data for write-back on load |
| imm | input | 32 | Instruction immediate |
| op_a | output | 32 | First operand, register at rs1_addr |
| op_b | output | 32 | Second operand, immediate or register at rs2_addr |
| dbg_digits | output | 56 | Low nibbles of registers 0 to 13, digit k in bits 4k+3:4k |

## Verification
A register written with the wrong word, written at the wrong address or corrupted by a disabled write stays wrong until rewritten, so it shows on `op_a` or `op_b` in the first cycle that names it as a source, and for registers 0 to 13 on `dbg_digits` one edge after the bad write. The bench keeps a shadow copy of all thirty-two registers and compares both operand ports against it every cycle with random addresses, so such a fault surfaces within a few cycles rather than only at a final dump. A wrong source selection shows at once on `op_b` or in the value read back one cycle after the write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int OPC_W = 5;

   localparam logic [OPC_W-1:0] OPC_LOAD     = 5'b10000;
   localparam logic [OPC_W-1:0] OPC_BRIMM    = 5'b10110;
   localparam logic [OPC_W-1:0] OPC_SETLTIMM = 5'b11111;

   // load selects memory data for write-back
   function automatic logic opc_is_load(input logic [OPC_W-1:0] opc);
      return opc == OPC_LOAD;
   endfunction

   // immediate-format opcodes take imm as the second operand
   function automatic logic opc_is_iform(input logic [OPC_W-1:0] opc);
      return (opc[OPC_W-1:OPC_W-2] == 2'b00) || (opc == OPC_LOAD) ||
             (opc == OPC_BRIMM) || (opc == OPC_SETLTIMM);
   endfunction

endpackage

// File: rtl/regbank_wb_sel.sv
module regbank_wb_sel
   import regbank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] alu_res,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] wb_data
);

   always_comb begin
      if (opc_is_load(opcode)) wb_data = mem_rdata;
      else                     wb_data = alu_res;
   end

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                waddr,
   input  logic [DATA_W-1:0]                wdata,
   input  logic [ADDR_W-1:0]                ra1,
   input  logic [ADDR_W-1:0]                ra2,
   output logic [DATA_W-1:0]                rdata1,
   output logic [DATA_W-1:0]                rdata2,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

   if (NUM_REGS < 2 || (1 << ADDR_W) < NUM_REGS) begin : g_bad_cfg
      $error("regbank_store: address width too small for register count");
   end

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      logic hit;
      assign hit = we && (waddr == ADDR_W'(gi));
      always_ff @(posedge clk) begin
         if (rst)      regs_q[gi] <= '0;
         else if (hit) regs_q[gi] <= wdata;
      end
   end

   // read ports see flop outputs, so a same-cycle write is not visible yet
   assign rdata1 = regs_q[ra1];
   assign rdata2 = regs_q[ra2];

   // R1
   reset_clears_chk: assert property (@(posedge clk) rst |=> (regs_q == '0))
      else $error("register not cleared by reset");

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> (regs_q[$past(waddr)] == $past(wdata)))
      else $error("written register does not hold write data");

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(regs_q))
      else $error("register changed without write enable");

endmodule

// File: rtl/regbank_digits.sv
module regbank_digits #(
   parameter int NUM_REGS   = 32,
   parameter int DATA_W     = 32,
   parameter int DBG_DIGITS = 14,
   parameter int DIGIT_W    = 4
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q,
   output logic [DBG_DIGITS*DIGIT_W-1:0]     digits
);

   if (DBG_DIGITS > NUM_REGS || DIGIT_W > DATA_W) begin : g_bad_cfg
      $error("regbank_digits: more digits than registers or digit wider than word");
   end

   for (genvar gd = 0; gd < DBG_DIGITS; gd++) begin : g_dig
      assign digits[gd*DIGIT_W +: DIGIT_W] = regs_q[gd][DIGIT_W-1:0];
   end

endmodule

// File: rtl/regbank_opsel.sv
module regbank_opsel
   import regbank_pkg::*;
#(
   parameter int NUM_REGS   = 32,
   parameter int DATA_W     = 32,
   parameter int DBG_DIGITS = 14,
   parameter int DIGIT_W    = 4,
   localparam int ADDR_W    = $clog2(NUM_REGS),
   localparam int DBG_W     = DBG_DIGITS * DIGIT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] rs1_addr,
   input  logic [ADDR_W-1:0] rs2_addr,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [DATA_W-1:0] alu_res,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b,
   output logic [DBG_W-1:0]  dbg_digits
);

   if (DATA_W < 1 || DIGIT_W < 1) begin : g_bad_cfg
      $error("regbank_opsel: widths must be positive");
   end

   logic [DATA_W-1:0]               wb_data;
   logic [DATA_W-1:0]               rs2_val;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

   regbank_wb_sel #(.DATA_W(DATA_W)) u_wb_sel (
      .opcode    (opcode),
      .alu_res   (alu_res),
      .mem_rdata (mem_rdata),
      .wb_data   (wb_data)
   );

   regbank_store #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W)
   ) u_store (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en),
      .waddr  (rd_addr),
      .wdata  (wb_data),
      .ra1    (rs1_addr),
      .ra2    (rs2_addr),
      .rdata1 (op_a),
      .rdata2 (rs2_val),
      .regs_q (regs_q)
   );

   regbank_digits #(
      .NUM_REGS   (NUM_REGS),
      .DATA_W     (DATA_W),
      .DBG_DIGITS (DBG_DIGITS),
      .DIGIT_W    (DIGIT_W)
   ) u_digits (
      .regs_q (regs_q),
      .digits (dbg_digits)
   );

   always_comb begin
      if (opc_is_iform(opcode)) op_b = imm;
      else                      op_b = rs2_val;
   end

   // R4
   load_source_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && opc_is_load(opcode)) |=> (regs_q[$past(rd_addr)] == $past(mem_rdata)))
      else $error("load did not write memory data");

   // R6
   imm_operand_chk: assert property (@(posedge clk) disable iff (rst)
      opc_is_iform(opcode) |-> (op_b == imm))
      else $error("immediate opcode did not route imm to op_b");

endmodule

// File: tb/regbank_opsel_bench.sv
`timescale 1ns/1ps
module regbank_opsel_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [4:0]  rd_addr, rs1_addr, rs2_addr, opcode;
   logic [31:0] alu_res, mem_rdata, imm;
   logic [31:0] op_a, op_b;
   logic [55:0] dbg_digits;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] shadow [32];

   always #4 clk = ~clk;

   regbank_opsel u_regbank_opsel (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_addr(rd_addr),
      .rs1_addr(rs1_addr), .rs2_addr(rs2_addr), .opcode(opcode),
      .alu_res(alu_res), .mem_rdata(mem_rdata), .imm(imm),
      .op_a(op_a), .op_b(op_b), .dbg_digits(dbg_digits)
   );

   function automatic bit exp_iform(input logic [4:0] o);
      return (o <= 5'd7) || o == 5'd16 || o == 5'd22 || o == 5'd31;
   endfunction

   function automatic logic [31:0] exp_wb(input logic [4:0] o, input logic [31:0] a, input logic [31:0] m);
      return (o == 5'd16) ? m : a;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, settle, check operands against shadow (old values), then clock
   task automatic cycle(input bit we, input logic [4:0] rd, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [4:0] opc,
                        input logic [31:0] a, input logic [31:0] m, input logic [31:0] im);
      @(negedge clk);
      wr_en = we; rd_addr = rd; rs1_addr = r1; rs2_addr = r2; opcode = opc;
      alu_res = a; mem_rdata = m; imm = im;
      #1;
      chk((we && r1 == rd) ? "R8 op_a" : "R5 op_a", op_a, shadow[r1]);
      chk(exp_iform(opc) ? "R6 op_b imm" : "R6 op_b reg", op_b,
          exp_iform(opc) ? im : shadow[r2]);
      @(posedge clk);
      if (we) shadow[rd] = exp_wb(opc, a, m);
   endtask

   task automatic check_digits(input string req);
      @(negedge clk);
      #1;
      for (int k = 0; k < 14; k++)
         chk(req, {28'd0, dbg_digits[4*k +: 4]}, {28'd0, shadow[k][3:0]});
   endtask

   task automatic dump_all(input string req);
      for (int r = 0; r < 32; r++) begin
         @(negedge clk);
         wr_en = 1'b0; rs1_addr = 5'(r); opcode = 5'd8;
         #1;
         chk(req, op_a, shadow[r]);
      end
   endtask

   initial begin
      void'($urandom(32'd20231));
      for (int r = 0; r < 32; r++) shadow[r] = '0;
      rst = 1'b1; wr_en = 1'b0; rd_addr = '0; rs1_addr = '0; rs2_addr = '0;
      opcode = 5'd8; alu_res = '1; mem_rdata = '1; imm = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1: reset state
      dump_all("R1 reset read");
      check_digits("R1 reset digits");

      // R7: register 0 writable
      cycle(1, 5'd0, 5'd0, 5'd1, 5'd8, 32'hDEAD_BEE5, 32'h1, 32'h0);
      cycle(0, 5'd0, 5'd0, 5'd0, 5'd8, 32'h0, 32'h0, 32'h0);
      chk("R7 x0 readback", shadow[0], 32'hDEAD_BEE5);

      // R4: load takes memory data, other opcode takes ALU result
      cycle(1, 5'd5, 5'd1, 5'd2, 5'd16, 32'h1111_1111, 32'h5555_AAAA, 32'h7);
      cycle(1, 5'd6, 5'd5, 5'd5, 5'd17, 32'h2222_3333, 32'h9999_9999, 32'h7);
      cycle(0, 5'd0, 5'd6, 5'd5, 5'd8, 32'h0, 32'h0, 32'h0);
      chk("R4 load wrote mem", shadow[5], 32'h5555_AAAA);
      chk("R4 store-op wrote alu", shadow[6], 32'h2222_3333);

      // R3: disabled write with load opcode changes nothing
      cycle(0, 5'd5, 5'd5, 5'd6, 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
      cycle(0, 5'd6, 5'd5, 5'd6, 5'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);

      // R8: write and read same register back to back
      cycle(1, 5'd9, 5'd9, 5'd9, 5'd9, 32'h0BAD_F00D, 32'h0, 32'h0);
      cycle(1, 5'd9, 5'd9, 5'd9, 5'd9, 32'h1234_5678, 32'h0, 32'h0);
      cycle(0, 5'd9, 5'd9, 5'd9, 5'd9, 32'h0, 32'h0, 32'h0);

      // R6: every immediate-set boundary opcode
      cycle(0, 5'd0, 5'd0, 5'd9, 5'd7,  32'h0, 32'h0, 32'hABCD_0007);
      cycle(0, 5'd0, 5'd0, 5'd9, 5'd22, 32'h0, 32'h0, 32'hABCD_0016);
      cycle(0, 5'd0, 5'd0, 5'd9, 5'd31, 32'h0, 32'h0, 32'hABCD_001F);
      cycle(0, 5'd0, 5'd0, 5'd9, 5'd23, 32'h0, 32'h0, 32'hABCD_0017);
      cycle(0, 5'd0, 5'd0, 5'd9, 5'd30, 32'h0, 32'h0, 32'hABCD_001E);

      // R9: distinct nibbles in registers 0..13
      for (int k = 0; k < 14; k++)
         cycle(1, 5'(k), 5'd31, 5'd30, 5'd0, {28'hA5A5_A5A, 4'(k + 1)}, 32'h0, 32'h0);
      check_digits("R9 debug digits");

      // random mix, R2 R3 R4 R5 R6 R8
      for (int n = 0; n < 600; n++)
         cycle($urandom_range(0, 3) != 0, 5'($urandom), 5'($urandom), 5'($urandom),
               5'($urandom), $urandom, $urandom, $urandom);
      check_digits("R9 digits after random");
      dump_all("R2 final contents");

      // R1: reset again after traffic
      @(negedge clk) rst = 1'b1;
      @(posedge clk);
      @(negedge clk) rst = 1'b0;
      for (int r = 0; r < 32; r++) shadow[r] = '0;
      dump_all("R1 second reset");

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule